// File: doc/BRIEF.md
# Register-Mapped MDIO Management Master

This block lets a host processor reach the management registers of external PHY devices over a two-wire MDIO bus, using Clause 22 frames. The host sees five 32-bit words on a simple register bus. The command word has a self-clearing start bit, an operation code and a read-only busy flag. The other words hold the clock divider setting, a packed PHY/register address, the write data and the captured read data.

A transaction runs in four steps. The host writes the divider, the address and, for a write, the data. It then writes the command word with the start bit set and the operation code. It polls busy until busy drops and, for a read, fetches the result. While busy is set, the block produces MDC from the system clock and shifts out a 64-bit frame. The frame is 32 preamble ones, start code 01, the opcode, 5-bit PHY and register fields, a 2-bit turnaround and 16 data bits, all sent MSB first. Outputs change on the falling edge of MDC. During a read the block lets go of the line from the turnaround onward and samples the PHY's data on rising edges of MDC.

Top module: `mdio_reg_master`

## Requirements
- R1: After reset, busy reads 0, MDC is low, the MDIO enable is 0, and the divider word at byte offset 0x40 reads 0x000150FF.
- R2: The address word at 0x44 keeps the PHY address in bits 12:8 and the register number in bits 4:0. All other bits read back as 0.
- R3: Busy (bit 16 of the command word at 0x50) reads 1 from the cycle after a start write (bit 8 set) until the frame ends. The start bit always reads back as 0.
- R4: A start write made while busy is set is ignored. The running frame keeps its length, its bits and its operation.
- R5: MDC stays low when idle. While a frame runs, each MDC half period lasts (divider + 1) system clock cycles, where the divider is bits 7:0 of word 0x40 taken at start. A frame has exactly 64 rising edges.
- R6: A write frame (operation code 1 in bit 0 of the command word) drives these bits MSB first: 32 ones, 01, 01, the PHY address, the register number, 10, and the 16 bits of word 0x48. Each bit is valid at the rising MDC edge.
- R7: A read frame (operation code 0) drives 32 ones, 01, 10, the PHY address and the register number. It releases MDIO from bit 46 (turnaround) onward. It samples 16 data bits MSB first on rising MDC edges 48 to 63 and returns them in word 0x4C once the frame ends.
- R8: Busy stays set for exactly 128 × (divider + 1) system clock cycles per frame. It clears with the last falling edge of MDC.
- R9: The MDIO output enable is 0 whenever busy is 0.
- R10: Bit 0 of the command word reads back the operation code of the last accepted transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 1 | Register bus select |
| regWr | input | 1 | Write strobe, qualified by regSel |
| regAddr | input | 8 | Byte offset of the accessed word |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value to drive when enabled |
| mdioOe | output | 1 | MDIO pad output enable |
| mdioIn | input | 1 | MDIO value seen at the pad |

## Verification
Most faults in the sequencer change how long busy stays set. A wrong divider count or a wrong bit counter stretches or shortens the busy window, or changes the number of MDC rising edges. This shows at the command word on the very frame that suffers the fault. A wrong shift or load of the frame shows as a wrong bit at a rising MDC edge, caught in the same frame. A wrong capture or commit of read data shows only when word 0x4C is read after busy drops. A stuck or wrong enable shows at the pad during the turnaround of a read, or during idle.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam logic [7:0] OFS_CFG   = 8'h40;
  localparam logic [7:0] OFS_ADDR  = 8'h44;
  localparam logic [7:0] OFS_WDATA = 8'h48;
  localparam logic [7:0] OFS_RDATA = 8'h4C;
  localparam logic [7:0] OFS_CMD   = 8'h50;
  localparam int START_BIT = 8;
  localparam int BUSY_BIT  = 16;
  localparam logic [31:0] CFG_RESET = 32'h0001_50FF;

  typedef struct packed {
    logic loadFrame;
    logic shiftBit;
    logic captureBit;
    logic commitRead;
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_seq_ctrl.sv
module mdio_seq_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int FRAME_W = 64,
  parameter int DATA_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             startOp,
  input  logic [DIV_W-1:0] divSel,
  output mdioStrobe_t      strobe,
  output logic             busy,
  output logic             mdc,
  output logic             mdioOe
);
  localparam int IDX_W = $clog2(FRAME_W);
  localparam int RELEASE_IDX = FRAME_W - DATA_W - 2;
  localparam int DATA_IDX = FRAME_W - DATA_W;
  localparam int LEN_W = IDX_W + DIV_W + 3;

  logic             runQ, mdcQ, opWrQ;
  logic [DIV_W-1:0] divCntQ, divLatQ;
  logic [IDX_W-1:0] bitIdxQ;
  logic             halfDone, rising, falling, lastBit;

  assign halfDone = runQ && (divCntQ == divLatQ);
  assign rising   = halfDone && !mdcQ;
  assign falling  = halfDone && mdcQ;
  assign lastBit  = (bitIdxQ == IDX_W'(FRAME_W - 1));

  always_comb begin
    strobe.loadFrame  = startReq && !runQ;
    strobe.shiftBit   = falling && !lastBit;
    strobe.captureBit = rising && !opWrQ && (bitIdxQ >= IDX_W'(DATA_IDX));
    strobe.commitRead = falling && lastBit && !opWrQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      mdcQ    <= 1'b0;
      opWrQ   <= 1'b0;
      divCntQ <= '0;
      divLatQ <= '0;
      bitIdxQ <= '0;
    end else if (strobe.loadFrame) begin
      runQ    <= 1'b1;
      mdcQ    <= 1'b0;
      opWrQ   <= startOp;
      divCntQ <= '0;
      divLatQ <= divSel;
      bitIdxQ <= '0;
    end else if (runQ) begin
      if (halfDone) begin
        divCntQ <= '0;
        mdcQ    <= !mdcQ;
        if (falling) begin
          if (lastBit) runQ <= 1'b0;
          else         bitIdxQ <= bitIdxQ + 1'b1;
        end
      end else begin
        divCntQ <= divCntQ + 1'b1;
      end
    end
  end

  assign busy   = runQ;
  assign mdc    = mdcQ;
  assign mdioOe = runQ && (opWrQ || (bitIdxQ < IDX_W'(RELEASE_IDX)));

  // Frame length checker: cycles spent busy, compared when busy falls.
  logic [LEN_W-1:0] lenCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 lenCnt <= '0;
    else if (strobe.loadFrame) lenCnt <= '0;
    else if (runQ)             lenCnt <= lenCnt + 1'b1;
  end

  p_busy_next_r3: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> busy);
  p_frame_len_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (lenCnt == LEN_W'(2 * FRAME_W) * (LEN_W'(divLatQ) + 1'b1)));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdioOe && !mdc));
  p_read_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !opWrQ && bitIdxQ >= IDX_W'(RELEASE_IDX)) |-> !mdioOe);
  p_start_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> (busy && $stable(opWrQ) && $stable(divLatQ)));
  p_mdc_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && divCntQ != divLatQ) |=> $stable(mdc));
endmodule

// File: rtl/mdio_regs_dp.sv
module mdio_regs_dp
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PHY_W = 5,
  parameter int REG_W = 5,
  parameter int DATA_W = 16,
  parameter int PRE_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic             regWr,
  input  logic [7:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  mdioStrobe_t      strobe,
  input  logic             busy,
  input  logic             mdioIn,
  output logic             startReq,
  output logic             startOp,
  output logic [DIV_W-1:0] divSel,
  output logic             mdioOut
);
  localparam int FRAME_W = PRE_W + 6 + PHY_W + REG_W + DATA_W;

  logic [31:0]        cfgQ;
  logic [PHY_W-1:0]   phyQ;
  logic [REG_W-1:0]   regQ;
  logic [DATA_W-1:0]  wrDataQ, rdDataQ, capQ;
  logic               lastOpQ;
  logic [FRAME_W-1:0] shiftQ;
  logic               wrHit;

  assign wrHit    = regSel && regWr;
  assign startReq = wrHit && (regAddr == OFS_CMD) && regWdata[START_BIT];
  assign startOp  = regWdata[0];
  assign divSel   = cfgQ[DIV_W-1:0];
  assign mdioOut  = shiftQ[FRAME_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= CFG_RESET;
      phyQ    <= '0;
      regQ    <= '0;
      wrDataQ <= '0;
    end else if (wrHit) begin
      if (regAddr == OFS_CFG)   cfgQ    <= regWdata;
      if (regAddr == OFS_ADDR)  {phyQ, regQ} <= {regWdata[8 +: PHY_W], regWdata[REG_W-1:0]};
      if (regAddr == OFS_WDATA) wrDataQ <= regWdata[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      lastOpQ <= 1'b0;
      capQ    <= '0;
      rdDataQ <= '0;
    end else begin
      if (strobe.loadFrame) begin
        lastOpQ <= startOp;
        shiftQ  <= {{PRE_W{1'b1}}, 2'b01, startOp ? 2'b01 : 2'b10, phyQ, regQ,
                    startOp ? 2'b10 : 2'b11, startOp ? wrDataQ : {DATA_W{1'b1}}};
      end else if (strobe.shiftBit) begin
        shiftQ <= {shiftQ[FRAME_W-2:0], 1'b0};
      end
      if (strobe.captureBit) capQ    <= {capQ[DATA_W-2:0], mdioIn};
      if (strobe.commitRead) rdDataQ <= capQ;
    end
  end

  always_comb begin
    case (regAddr)
      OFS_CFG:   regRdata = cfgQ;
      OFS_ADDR:  regRdata = (32'(phyQ) << 8) | 32'(regQ);
      OFS_WDATA: regRdata = 32'(wrDataQ);
      OFS_RDATA: regRdata = 32'(rdDataQ);
      OFS_CMD:   regRdata = (32'(busy) << BUSY_BIT) | 32'(lastOpQ);
      default:   regRdata = '0;
    endcase
  end

  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(rdDataQ));
  p_op_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(lastOpQ));
endmodule

// File: rtl/mdio_reg_master.sv
module mdio_reg_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PHY_W = 5,
  parameter int REG_W = 5,
  parameter int DATA_W = 16,
  parameter int PRE_W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regSel,
  input  logic        regWr,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  localparam int FRAME_W = PRE_W + 6 + PHY_W + REG_W + DATA_W;

  mdioStrobe_t      strobe;
  logic             busy, startReq, startOp;
  logic [DIV_W-1:0] divSel;

  mdio_regs_dp #(.DIV_W(DIV_W), .PHY_W(PHY_W), .REG_W(REG_W),
                 .DATA_W(DATA_W), .PRE_W(PRE_W)) i_dp (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .strobe(strobe), .busy(busy), .mdioIn(mdioIn),
    .startReq(startReq), .startOp(startOp), .divSel(divSel),
    .mdioOut(mdioOut));

  mdio_seq_ctrl #(.DIV_W(DIV_W), .FRAME_W(FRAME_W), .DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startOp(startOp),
    .divSel(divSel), .strobe(strobe), .busy(busy), .mdc(mdc),
    .mdioOe(mdioOe));
endmodule

// File: tb/test_mdio_reg_master.sv
module test_mdio_reg_master;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        regSel = 1'b0, regWr = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        mdc, mdioOut, mdioOe, mdioIn;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [63:0] obsBits = '0, oeHist = '0;
  int unsigned riseTotal = 0, riseBase = 0;
  logic [15:0] phyWord = '0;

  always #10 clk = ~clk;

  mdio_reg_master i_mdio_reg_master (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn));

  // Bench-side PHY: records what is on the line at each rising MDC edge.
  always @(posedge mdc) begin
    obsBits   <= {obsBits[62:0], mdioOe ? mdioOut : 1'b0};
    oeHist    <= {oeHist[62:0], mdioOe};
    riseTotal <= riseTotal + 1;
  end

  function automatic logic phyBit(input int unsigned k, input logic [15:0] w);
    if (k >= 48 && k < 64) return w[63 - k];
    return 1'b1;
  endfunction
  assign mdioIn = phyBit(riseTotal - riseBase, phyWord);

  function automatic logic [63:0] expFrame(input bit op, input logic [4:0] phy,
      input logic [4:0] rg, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, op ? 2'b01 : 2'b10, phy, rg,
            op ? 2'b10 : 2'b00, op ? wd : 16'h0000};
  endfunction

  function automatic logic [63:0] expOe(input bit op);
    return op ? 64'hFFFF_FFFF_FFFF_FFFF : {{46{1'b1}}, 18'h0};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regSel = 1'b1; regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regSel = 1'b0; regWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic xfer(input bit op, input logic [4:0] phy, input logic [4:0] rg,
      input logic [15:0] wd, input logic [7:0] div, input logic [15:0] pd,
      input bit inject);
    int cnt;
    logic [31:0] rd;
    busWrite(8'h40, 32'h0001_5000 | 32'(div));
    busWrite(8'h44, (32'(phy) << 8) | 32'(rg));
    busWrite(8'h48, 32'(wd));
    phyWord  = pd;
    riseBase = riseTotal;
    busWrite(8'h50, 32'h100 | 32'(op));
    regAddr = 8'h50;
    #1;
    chk("R3 busy after start", 64'(regRdata[16]), 64'd1);
    chk("R3 start reads 0", 64'(regRdata[8]), 64'd0);
    cnt = 0;
    while (regRdata[16] && cnt < 100000) begin
      cnt++;
      if (inject && cnt == 40) begin
        regSel = 1'b1; regWr = 1'b1; regWdata = 32'h100 | 32'(!op);
      end else begin
        regSel = 1'b0; regWr = 1'b0;
      end
      @(negedge clk);
      #1;
    end
    regSel = 1'b0; regWr = 1'b0;
    chk(inject ? "R4 length kept" : "R8 busy length", 64'(cnt), 64'(128 * (int'(div) + 1)));
    chk("R5 rising edges", 64'(riseTotal - riseBase), 64'd64);
    chk(op ? "R6 write frame" : "R7 read frame", obsBits & expOe(op),
        expFrame(op, phy, rg, wd) & expOe(op));
    chk("R7 enable pattern", oeHist, expOe(op));
    chk("R9 idle enable", 64'({mdioOe, mdc}), 64'd0);
    busRead(8'h50, rd);
    chk("R10 op readback", 64'(rd), 64'(op));
    if (!op) begin
      busRead(8'h4C, rd);
      chk("R7 read data", 64'(rd), 64'(pd));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    busRead(8'h40, rd);
    chk("R1 divider reset", 64'(rd), 64'h0001_50FF);
    busRead(8'h50, rd);
    chk("R1 command reset", 64'(rd), 64'd0);
    chk("R1 pad idle", 64'({mdc, mdioOe}), 64'd0);

    busWrite(8'h44, 32'hFFFF_FFFF);
    busRead(8'h44, rd);
    chk("R2 address packing", 64'(rd), 64'h0000_1F1F);

    xfer(1'b1, 5'h15, 5'h0A, 16'hA5C3, 8'd0, 16'h0000, 1'b0);
    xfer(1'b0, 5'h01, 5'h1F, 16'hFFFF, 8'd2, 16'h8001, 1'b0);
    xfer(1'b0, 5'h1F, 5'h00, 16'h0000, 8'd1, 16'h5A3C, 1'b1);
    xfer(1'b1, 5'h00, 5'h11, 16'h0001, 8'd1, 16'h0000, 1'b1);
    for (int i = 0; i < 8; i++) begin
      xfer(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
           8'($urandom % 4), 16'($urandom), 1'b0);
    end
    xfer(1'b0, 5'h0C, 5'h03, 16'h0000, 8'hFF, 16'hC0DE, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule